// File: doc/BRIEF.md
# Dual-Channel Core Watchdog with Warning Watermark

This block supervises two processor cores that share one subsystem clock. Each core has its own channel built around a 32-bit down-counter. Software arms a channel by writing a start value into its load register and setting the run bit. From then on the counter loses one per clock. Writing the load register again puts a fresh value into the counter, and that is how the core proves it is still alive.

A channel that reaches zero stops there and latches a timeout. A timeout on either channel raises its own timeout interrupt and also raises one reset request that covers both cores. Ahead of that, software can set a watermark. When the count equals the watermark, a sticky warning bit is set, and the warning interrupt fires if it is enabled. While a core's debug-acknowledge input is high, that core's counter is frozen.

The register bus is a simple single-cycle write port with a combinational read port. Address bit 3 selects the channel. Address bits 2:0 select the register: 0 control (bit 0 run, bit 1 warning enable), 1 load, 2 count (read-only), 3 watermark, 4 status (bit 0 warning, bit 1 timeout, write 1 to clear). Unmapped offsets read as zero.

Top module: `dual_core_watchdog`

## Requirements
- R1: After reset, every register of both channels reads 0, and all interrupt outputs and `rst_req` are 0.
- R2: A write to the load register (offset 1) puts the written value into that channel's counter, and the count register (offset 2) returns it.
- R3: The counter drops by exactly one per clock only while control bit 0 is 1. With bit 0 at 0 it holds its value.
- R4: While the channel's `dbg_ack` bit is 1, its counter holds its value. Counting resumes once `dbg_ack` returns to 0.
- R5: A counter that decrements to zero stays at zero and sets status bit 1 (timeout). The timeout interrupt of that channel equals status bit 1.
- R6: `rst_req` is 1 whenever either channel's timeout status is set. The two channels count independently of each other.
- R7: Status bit 0 (warning) is set one clock after the count first equals the watermark, including the case where a load or a watermark write makes them equal. The warning interrupt is status bit 0 ANDed with control bit 1.
- R8: A match that persists does not set the warning again: once the bit is cleared, it stays 0 for as long as count and watermark stay equal.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A load write also clears the timeout bit.
- R10: Writes to the count register (offset 2) have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subsystem clock shared by both channels |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address: bit 3 selects the channel, bits 2:0 select the register |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| dbg_ack | input | 2 | Per-core debug acknowledge; freezes that channel's counter |
| irq_warn | output | 2 | Per-channel warning interrupt |
| irq_tmo | output | 2 | Per-channel timeout interrupt |
| rst_req | output | 1 | Subsystem reset request, raised by a timeout on either channel |

## Verification
The hardest case to reach is a match that lasts for many cycles, where the warning must not fire again after software clears it. A running counter passes each value in a single clock, so this case cannot be reached that way. The bench holds `dbg_ack` high to freeze the channel and then makes count equal the watermark through register writes. It first parks the watermark on all-ones, then loads the count, then writes the watermark to match. After that it clears the warning and checks that the bit stays clear over several idle cycles. A table of load, watermark and run-length vectors covers warnings that fire on the last counted cycle, on the load itself, and at zero together with a timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Register offsets within one channel (address bits 2:0)
  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_LOAD  = 3'd1;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_MARK  = 3'd3;
  localparam logic [2:0] OFS_STAT  = 3'd4;
  localparam int OFS_W = 3;

  // Control field positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_WEN  = 1;
  // Status field positions
  localparam int STAT_WARN = 0;
  localparam int STAT_TMO  = 1;

  typedef struct packed {
    logic ctrl;
    logic load;
    logic mark;
    logic stat;
  } wr_strobe_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/wdog_channel.sv
module wdog_channel
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_ack,
  input  wr_strobe_t       wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [1:0]       ctrl,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] mark,
  output logic [1:0]       stat,
  output logic             irq_warn,
  output logic             irq_tmo
);
  logic [1:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mark_q, mark_d;
  logic [1:0]       stat_q, stat_d;
  logic             hit_q, hit;
  logic             run, tmo_evt, warn_evt;

  // Next-state logic
  always_comb begin
    run      = ctrl_q[CTRL_RUN] & ~dbg_ack & (cnt_q != '0);
    hit      = (cnt_q == mark_q);
    warn_evt = hit & ~hit_q;
    tmo_evt  = ~wr.load & run & (cnt_q == CNT_W'(1));

    cnt_d = cnt_q;
    if (wr.load)  cnt_d = wdata;
    else if (run) cnt_d = cnt_q - CNT_W'(1);

    ctrl_d = wr.ctrl ? wdata[1:0] : ctrl_q;
    mark_d = wr.mark ? wdata : mark_q;

    stat_d[STAT_WARN] = warn_evt |
                        (stat_q[STAT_WARN] & ~(wr.stat & wdata[STAT_WARN]));
    stat_d[STAT_TMO]  = tmo_evt |
                        (stat_q[STAT_TMO] & ~(wr.stat & wdata[STAT_TMO]) & ~wr.load);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      mark_q <= '0;
      stat_q <= '0;
      hit_q  <= 1'b1;  // count == mark at reset must not raise a warning
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      mark_q <= mark_d;
      stat_q <= stat_d;
      hit_q  <= hit;
    end
  end

  assign ctrl     = ctrl_q;
  assign count    = cnt_q;
  assign mark     = mark_q;
  assign stat     = stat_q;
  assign irq_warn = stat_q[STAT_WARN] & ctrl_q[CTRL_WEN];
  assign irq_tmo  = stat_q[STAT_TMO];

  // Assertions
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_RUN] && !dbg_ack && cnt_q != '0 && !wr.load)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_RUN] && !wr.load) |=> $stable(cnt_q));

  assert_dbg_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ack && !wr.load) |=> $stable(cnt_q));

  assert_zero_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr.load) |=> (cnt_q == '0));

  assert_tmo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[STAT_TMO] && !wr.load && !(wr.stat && wdata[STAT_TMO]))
      |=> stat_q[STAT_TMO]);

  assert_warn_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[STAT_WARN] && cnt_q == mark_q &&
     $past(cnt_q) == cnt_q && $past(mark_q) == mark_q &&
     !wr.load && !wr.mark) |=> !stat_q[STAT_WARN]);
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int N_CH  = 2,
  parameter int CNT_W = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + OFS_W
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [N_CH-1:0][1:0]        ctrl_all,
  input  logic [N_CH-1:0][CNT_W-1:0]  cnt_all,
  input  logic [N_CH-1:0][CNT_W-1:0]  mark_all,
  input  logic [N_CH-1:0][1:0]        stat_all,
  output logic [CNT_W-1:0]            rdata
);
  logic [CH_W-1:0]  ch;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    ch    = addr[ADDR_W-1:OFS_W];
    ofs   = addr[OFS_W-1:0];
    rdata = '0;
    case (ofs)
      OFS_CTRL:  rdata[1:0] = ctrl_all[ch];
      OFS_COUNT: rdata      = cnt_all[ch];
      OFS_MARK:  rdata      = mark_all[ch];
      OFS_STAT:  rdata[1:0] = stat_all[ch];
      default:   rdata      = '0;
    endcase
  end
endmodule

// File: rtl/dual_core_watchdog.sv
module dual_core_watchdog
  import wdog_pkg::*;
#(
  parameter int N_CH  = 2,
  parameter int CNT_W = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_CH-1:0]   dbg_ack,
  output logic [N_CH-1:0]   irq_warn,
  output logic [N_CH-1:0]   irq_tmo,
  output logic              rst_req
);
  logic rst_s;
  logic [N_CH-1:0][1:0]       ctrl_all;
  logic [N_CH-1:0][CNT_W-1:0] cnt_all;
  logic [N_CH-1:0][CNT_W-1:0] mark_all;
  logic [N_CH-1:0][1:0]       stat_all;

  wdog_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    wr_strobe_t wr_c;
    logic       sel;

    always_comb begin
      sel       = bus_wen && (bus_addr[ADDR_W-1:OFS_W] == CH_W'(c));
      wr_c.ctrl = sel && (bus_addr[OFS_W-1:0] == OFS_CTRL);
      wr_c.load = sel && (bus_addr[OFS_W-1:0] == OFS_LOAD);
      wr_c.mark = sel && (bus_addr[OFS_W-1:0] == OFS_MARK);
      wr_c.stat = sel && (bus_addr[OFS_W-1:0] == OFS_STAT);
    end

    wdog_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_s),
      .dbg_ack  (dbg_ack[c]),
      .wr       (wr_c),
      .wdata    (bus_wdata),
      .ctrl     (ctrl_all[c]),
      .count    (cnt_all[c]),
      .mark     (mark_all[c]),
      .stat     (stat_all[c]),
      .irq_warn (irq_warn[c]),
      .irq_tmo  (irq_tmo[c])
    );
  end

  wdog_rdmux #(.N_CH(N_CH), .CNT_W(CNT_W)) u_rd (
    .addr     (bus_addr),
    .ctrl_all (ctrl_all),
    .cnt_all  (cnt_all),
    .mark_all (mark_all),
    .stat_all (stat_all),
    .rdata    (bus_rdata)
  );

  always_comb begin
    rst_req = 1'b0;
    for (int c = 0; c < N_CH; c++) rst_req = rst_req | stat_all[c][STAT_TMO];
  end

  // A timeout interrupt seen on a port must be mirrored by the reset request
  assert_rst_req_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_tmo != '0) |-> rst_req);
endmodule

// File: tb/dual_core_watchdog_tb.sv
`timescale 1ns/1ps
module dual_core_watchdog_tb_top;
  localparam int NV = 8;
  localparam logic [3:0] C0_CTRL = 4'h0, C0_LOAD = 4'h1, C0_CNT = 4'h2,
                         C0_MARK = 4'h3, C0_STAT = 4'h4;
  localparam logic [3:0] C1_CTRL = 4'h8, C1_LOAD = 4'h9, C1_CNT = 4'hA,
                         C1_STAT = 4'hC;

  // Vector table: load value, watermark, idle cycles while running, expected results
  localparam logic [31:0] V_LOAD [NV] = '{32'd20, 32'd20, 32'd20, 32'd5,
                                          32'd7, 32'd7, 32'd1, 32'h8000_0000};
  localparam logic [31:0] V_MARK [NV] = '{32'd10, 32'd14, 32'd20, 32'd0,
                                          32'd3, 32'd0, 32'd100, 32'h7FFF_FFF0};
  localparam int          V_RUN  [NV] = '{5, 5, 3, 10, 5, 5, 0, 4};
  localparam logic [31:0] V_ECNT [NV] = '{32'd14, 32'd14, 32'd16, 32'd0,
                                          32'd1, 32'd1, 32'd0, 32'h7FFF_FFFB};
  localparam logic        V_EWRN [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic        V_ETMO [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  dbg_ack;
  logic [1:0]  irq_warn;
  logic [1:0]  irq_tmo;
  logic        rst_req;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dual_core_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_ack(dbg_ack),
    .irq_warn(irq_warn), .irq_tmo(irq_tmo), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; dbg_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(C0_CNT, rv);  check("R1 cnt0", rv, 0);
    rd(C1_CNT, rv);  check("R1 cnt1", rv, 0);
    rd(C0_STAT, rv); check("R1 stat0", rv, 0);
    rd(C0_CTRL, rv); check("R1 ctrl0", rv, 0);
    check("R1 irqs", {28'd0, irq_warn, irq_tmo}, 0);
    check("R1 rst_req", {31'd0, rst_req}, 0);

    // Table walk on channel 0 (R2, R3, R5, R7)
    for (int i = 0; i < NV; i++) begin
      wr(C0_CTRL, 0);
      wr(C0_MARK, 32'hFFFF_FFFF);
      wr(C0_LOAD, V_LOAD[i]);
      rd(C0_CNT, rv); check("R2 load", rv, V_LOAD[i]);
      wr(C0_STAT, 3);
      wr(C0_MARK, V_MARK[i]);
      @(negedge clk);
      wr(C0_CTRL, 3);
      for (int k = 0; k < V_RUN[i]; k++) @(negedge clk);
      wr(C0_CTRL, 2);
      @(negedge clk);
      rd(C0_CNT, rv);  check("R3 count", rv, V_ECNT[i]);
      rd(C0_STAT, rv); check("R7 R5 status", rv, {30'd0, V_ETMO[i], V_EWRN[i]});
      check("R7 irq_warn", {31'd0, irq_warn[0]}, {31'd0, V_EWRN[i]});
      check("R5 irq_tmo", {31'd0, irq_tmo[0]}, {31'd0, V_ETMO[i]});
      check("R6 rst_req", {31'd0, rst_req}, {31'd0, V_ETMO[i]});
    end

    // R4: freeze under debug acknowledge, then resume
    wr(C0_CTRL, 0);
    wr(C0_LOAD, 50);
    dbg_ack = 2'b01;
    wr(C0_CTRL, 1);
    repeat (10) @(negedge clk);
    rd(C0_CNT, rv); check("R4 frozen", rv, 50);
    dbg_ack = 2'b00;
    repeat (4) @(negedge clk);
    rd(C0_CNT, rv); check("R4 resumed", rv, 46);
    wr(C0_CTRL, 0);
    rd(C0_CNT, rv); check("R3 stop", rv, 45);

    // R10: count register is read-only
    wr(C0_CNT, 32'd7);
    rd(C0_CNT, rv); check("R10 ro", rv, 45);

    // R7/R8: persistent match while frozen
    dbg_ack = 2'b01;
    wr(C0_CTRL, 3);
    wr(C0_MARK, 32'hFFFF_FFFF);
    wr(C0_LOAD, 30);
    wr(C0_STAT, 3);
    wr(C0_MARK, 30);
    @(negedge clk);
    check("R7 warn irq", {31'd0, irq_warn[0]}, 1);
    wr(C0_CTRL, 1);
    check("R7 gated", {31'd0, irq_warn[0]}, 0);
    rd(C0_STAT, rv); check("R7 status kept", rv, 1);
    wr(C0_STAT, 0);
    rd(C0_STAT, rv); check("R9 write0", rv, 1);
    wr(C0_CTRL, 3);
    wr(C0_STAT, 1);
    repeat (5) @(negedge clk);
    rd(C0_STAT, rv); check("R8 no refire", rv, 0);
    check("R8 irq low", {31'd0, irq_warn[0]}, 0);
    rd(C0_CNT, rv);  check("R4 held at mark", rv, 30);

    // R6: channel 1 times out alone
    wr(C1_LOAD, 3);
    wr(C1_CTRL, 1);
    repeat (5) @(negedge clk);
    rd(C1_CNT, rv); check("R5 ch1 zero", rv, 0);
    check("R6 irq_tmo", {30'd0, irq_tmo}, 2);
    check("R6 rst_req", {31'd0, rst_req}, 1);
    rd(C0_CNT, rv); check("R6 ch0 untouched", rv, 30);

    // R9: W1C timeout stays clear at zero, then a load also clears
    wr(C1_STAT, 2);
    repeat (3) @(negedge clk);
    check("R9 w1c tmo", {31'd0, rst_req}, 0);
    rd(C1_CNT, rv); check("R5 still zero", rv, 0);
    wr(C1_LOAD, 2);
    repeat (4) @(negedge clk);
    check("R5 second tmo", {30'd0, irq_tmo}, 2);
    wr(C1_CTRL, 0);
    wr(C1_LOAD, 100);
    check("R9 load clears", {30'd0, irq_tmo}, 0);
    check("R9 rst_req low", {31'd0, rst_req}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule